// File: doc/BRIEF.md
# External Data Memory Access Router

This block sits between a small processor core and its external data space. For every load or store in that space, it decides whether the transfer goes to the on-chip RAM or to the off-chip memory bus. When the transfer goes off-chip, it forms the bus address. Two things decide the outcome: a 2-bit mode field and the width of the pointer the core used. The pointer is either an 8-bit register pointer or a 16-bit data pointer. In bank-select split mode, an 8-bit pointer is extended by a page register. In the all-external mode, the upper address byte of an 8-bit access is left undriven, so surrounding logic may own those pins.

The core side is a request/ready handshake. The core raises `cpu_req` with its fields and holds it, with all fields unchanged, until it sees `cpu_ready` high for one cycle. That ready cycle is the only back-pressure signal. The core may present the next request in the very next cycle. An on-chip transfer strobes the RAM port in the cycle the request is accepted and completes one cycle later. An off-chip transfer registers the whole bus state at acceptance. It holds `cpu_ready` low for `WAIT_CYCLES` cycles, then completes.

Top module: `xdm_router`

## Requirements
- R1: With `cfg_mode`=2'b10 and `cpu_wide`=0, the effective address is {`cfg_page`,`cpu_ptr`}. When it is below 0x1000, the access goes on-chip with `ram_addr` equal to its low 12 bits.
- R2: With `cfg_mode`=2'b10 and `cpu_wide`=0, an effective address of 0x1000 or more goes off-chip. `ext_addr`={`cfg_page`,`cpu_ptr`}, and both `ext_addr_hi_oe` and `ext_addr_lo_oe` are high.
- R3: With `cpu_wide`=1 in modes 2'b10 and 2'b11, `cpu_dptr` is the effective address. Mode 2'b10 routes it by the 0x1000 boundary. An off-chip transfer drives all 16 bits with both address enables high.
- R4: In mode 2'b11 every access goes off-chip, and `ram_en` is never asserted.
- R5: In mode 2'b11 with `cpu_wide`=0, `ext_addr`[7:0]=`cpu_ptr`, `ext_addr`[15:8]=0, and `ext_addr_hi_oe` is low. `cfg_page` has no effect.
- R6: In modes 2'b00 and 2'b01 every access goes on-chip. `ram_addr` is the low 12 bits of `cpu_dptr` (wide) or of {`cfg_page`,`cpu_ptr`} (narrow).
- R7: On-chip access: `ram_en` is high in the acceptance cycle, with `ram_we`=`cpu_we` and `ram_wdata`=`cpu_wdata`. `cpu_ready` is high in the next cycle, with `cpu_rdata`=`ram_rdata`.
- R8: Off-chip access: `cpu_ready` is low for `WAIT_CYCLES` cycles after acceptance and high in the cycle after those. In that ready cycle `cpu_rdata`=`ext_rdata`.
- R9: Off-chip bus state is registered at acceptance and holds until the ready cycle, inclusive. That state is the address, the enables, `ext_rd`=!`cpu_we`, `ext_we`=`cpu_we`, and `ext_wdata`; `ext_wdata_oe` is high only for writes.
- R10: Outside an off-chip transfer, `ext_addr_hi_oe`, `ext_addr_lo_oe`, `ext_wdata_oe`, `ext_rd` and `ext_we` are low.
- R11: `cpu_ready` lasts one cycle. A request still held high during the ready cycle does not start a new access in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Routing mode |
| cfg_page | input | 8 | Page register for 8-bit pointers |
| cpu_req | input | 1 | Request valid, held until ready |
| cpu_ready | output | 1 | One-cycle completion |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_wide | input | 1 | 1 = 16-bit data pointer, 0 = 8-bit pointer |
| cpu_ptr | input | 8 | 8-bit register pointer |
| cpu_dptr | input | 16 | 16-bit data pointer |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid with ready |
| ram_en | output | 1 | On-chip RAM strobe |
| ram_we | output | 1 | On-chip RAM write |
| ram_addr | output | 12 | On-chip RAM address |
| ram_wdata | output | 8 | On-chip RAM write data |
| ram_rdata | input | 8 | On-chip RAM data, one cycle after strobe |
| ext_addr | output | 16 | Off-chip address |
| ext_addr_hi_oe | output | 1 | Drive enable for address bits 15:8 |
| ext_addr_lo_oe | output | 1 | Drive enable for address bits 7:0 |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_we | output | 1 | Off-chip write strobe |
| ext_wdata | output | 8 | Off-chip write data |
| ext_wdata_oe | output | 1 | Drive enable for write data |
| ext_rdata | input | 8 | Off-chip read data |

## Verification
Two events can fall in the same cycle: the completion of one transfer, and the core already presenting (or still holding) a request. On some transfers the bench keeps `cpu_req` high straight through the ready cycle and changes the fields in the next cycle. In the ready cycle it checks that the RAM port stays quiet. In the following cycle it checks that the new access is accepted while the off-chip enables have already been released. The sweep covers every mode, both pointer widths, and loads and stores. It places pages and pointers on both sides of the 4 kB boundary, and it alternates back-to-back transfers with idle gaps.

// File: rtl/xdm_pkg.sv
`timescale 1ns/1ps
package xdm_pkg;
  typedef enum logic [1:0] {
    XM_LOCAL0 = 2'b00,
    XM_LOCAL1 = 2'b01,
    XM_SPLIT  = 2'b10,
    XM_EXT    = 2'b11
  } xmode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCAL = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } xstate_e;
endpackage

// File: rtl/xdm_route_decode.sv
`timescale 1ns/1ps
module xdm_route_decode
  import xdm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PTR_W    = 8,
  parameter int LOCAL_AW = 12
) (
  input  logic [1:0]              mode,
  input  logic [ADDR_W-PTR_W-1:0] page,
  input  logic                    wide,
  input  logic [PTR_W-1:0]        ptr,
  input  logic [ADDR_W-1:0]       dptr,
  output logic                    go_off,
  output logic                    drive_hi,
  output logic [ADDR_W-1:0]       eff_addr
);
  localparam int PAGE_W = ADDR_W - PTR_W;

  logic [ADDR_W-1:0] narrow_addr;
  logic              above_local;
  xmode_e            mode_e;

  assign mode_e = xmode_e'(mode);

  always_comb begin
    if (mode_e == XM_EXT) narrow_addr = {{PAGE_W{1'b0}}, ptr};
    else                  narrow_addr = {page, ptr};
  end

  assign eff_addr = wide ? dptr : narrow_addr;

  generate
    if (LOCAL_AW < ADDR_W) begin : g_boundary
      assign above_local = |eff_addr[ADDR_W-1:LOCAL_AW];
    end else begin : g_no_boundary
      assign above_local = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (mode_e)
      XM_EXT:   go_off = 1'b1;
      XM_SPLIT: go_off = above_local;
      default:  go_off = 1'b0;
    endcase
  end

  assign drive_hi = go_off & (wide | (mode_e != XM_EXT));
endmodule

// File: rtl/xdm_bus_seq.sv
`timescale 1ns/1ps
module xdm_bus_seq
  import xdm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              go_off,
  input  logic              drive_hi,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              accept,
  output logic              local_done,
  output logic              ext_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_hi_oe,
  output logic              bus_lo_oe,
  output logic              bus_rd,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_oe
);
  localparam int CNT_W  = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam int PAGE_W = ADDR_W / 2;

  xstate_e state_q, state_d;
  logic    cnt_zero;

  assign accept     = req && (state_q == ST_IDLE);
  assign local_done = (state_q == ST_LOCAL);
  assign ext_done   = (state_q == ST_DONE);

  generate
    if (WAIT_CYCLES > 0) begin : g_wait_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (accept)                              cnt_q <= CNT_W'(WAIT_CYCLES - 1);
        else if (state_q == ST_WAIT && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign cnt_zero = (cnt_q == '0);

      AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (int'(cnt_q) < WAIT_CYCLES)); // R8
    end else begin : g_no_wait
      assign cnt_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = !go_off ? ST_LOCAL :
                                      (WAIT_CYCLES == 0) ? ST_DONE : ST_WAIT;
      ST_WAIT:  if (cnt_zero) state_d = ST_DONE;
      ST_LOCAL: state_d = ST_IDLE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state_q == ST_DONE) begin
      bus_addr     <= '0;
      bus_hi_oe    <= 1'b0;
      bus_lo_oe    <= 1'b0;
      bus_rd       <= 1'b0;
      bus_we       <= 1'b0;
      bus_wdata    <= '0;
      bus_wdata_oe <= 1'b0;
    end else if (accept && go_off) begin
      bus_addr     <= drive_hi ? eff_addr
                               : {{PAGE_W{1'b0}}, eff_addr[ADDR_W-PAGE_W-1:0]};
      bus_hi_oe    <= drive_hi;
      bus_lo_oe    <= 1'b1;
      bus_rd       <= !we;
      bus_we       <= we;
      bus_wdata    <= wdata;
      bus_wdata_oe <= we;
    end
  end

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WAIT || state_q == ST_DONE) && $past(state_q == ST_WAIT))
      |-> ($stable(bus_addr) && $stable(bus_hi_oe) && $stable(bus_wdata) && $stable(bus_we))); // R9

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_LOCAL)
      |-> (!bus_hi_oe && !bus_lo_oe && !bus_wdata_oe && !bus_rd && !bus_we)); // R10
endmodule

// File: rtl/xdm_router.sv
`timescale 1ns/1ps
module xdm_router
  import xdm_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PTR_W       = 8,
  parameter int DATA_W      = 8,
  parameter int LOCAL_AW    = 12,
  parameter int WAIT_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_mode,
  input  logic [ADDR_W-PTR_W-1:0] cfg_page,
  input  logic                    cpu_req,
  output logic                    cpu_ready,
  input  logic                    cpu_we,
  input  logic                    cpu_wide,
  input  logic [PTR_W-1:0]        cpu_ptr,
  input  logic [ADDR_W-1:0]       cpu_dptr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    ram_en,
  output logic                    ram_we,
  output logic [LOCAL_AW-1:0]     ram_addr,
  output logic [DATA_W-1:0]       ram_wdata,
  input  logic [DATA_W-1:0]       ram_rdata,
  output logic [ADDR_W-1:0]       ext_addr,
  output logic                    ext_addr_hi_oe,
  output logic                    ext_addr_lo_oe,
  output logic                    ext_rd,
  output logic                    ext_we,
  output logic [DATA_W-1:0]       ext_wdata,
  output logic                    ext_wdata_oe,
  input  logic [DATA_W-1:0]       ext_rdata
);
  logic              go_off, drive_hi, accept, local_done, ext_done;
  logic [ADDR_W-1:0] eff_addr;

  xdm_route_decode #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LOCAL_AW(LOCAL_AW)
  ) u_decode (
    .mode(cfg_mode), .page(cfg_page), .wide(cpu_wide), .ptr(cpu_ptr),
    .dptr(cpu_dptr), .go_off(go_off), .drive_hi(drive_hi), .eff_addr(eff_addr)
  );

  xdm_bus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_CYCLES(WAIT_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .go_off(go_off),
    .drive_hi(drive_hi), .eff_addr(eff_addr), .wdata(cpu_wdata),
    .accept(accept), .local_done(local_done), .ext_done(ext_done),
    .bus_addr(ext_addr), .bus_hi_oe(ext_addr_hi_oe), .bus_lo_oe(ext_addr_lo_oe),
    .bus_rd(ext_rd), .bus_we(ext_we), .bus_wdata(ext_wdata),
    .bus_wdata_oe(ext_wdata_oe)
  );

  assign ram_en    = accept && !go_off;
  assign ram_we    = ram_en && cpu_we;
  assign ram_addr  = eff_addr[LOCAL_AW-1:0];
  assign ram_wdata = cpu_wdata;

  assign cpu_ready = local_done || ext_done;
  assign cpu_rdata = ext_done ? ext_rdata : ram_rdata;

  AST_NO_RAM_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (cfg_mode != 2'b11)); // R4

  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    ext_addr_hi_oe |-> ext_addr_lo_oe); // R2

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R11

  AST_NO_RAM_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !ram_en); // R11
endmodule

// File: tb/xdm_router_tb.sv
`timescale 1ns/1ps
module xdm_router_tb;
  localparam int W = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [7:0]  cfg_page = 8'h00;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wide = 1'b0;
  logic [7:0]  cpu_ptr = 8'h00, cpu_wdata = 8'h00;
  logic [15:0] cpu_dptr = 16'h0000;
  logic        cpu_ready, ram_en, ram_we, ext_addr_hi_oe, ext_addr_lo_oe;
  logic        ext_rd, ext_we, ext_wdata_oe;
  logic [7:0]  cpu_rdata, ram_wdata, ext_wdata, ext_rdata;
  logic [7:0]  ram_rdata = 8'h00;
  logic [11:0] ram_addr;
  logic [15:0] ext_addr;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  xdm_router #(.WAIT_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_page(cfg_page),
    .cpu_req(cpu_req), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_wide(cpu_wide),
    .cpu_ptr(cpu_ptr), .cpu_dptr(cpu_dptr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ext_addr(ext_addr), .ext_addr_hi_oe(ext_addr_hi_oe),
    .ext_addr_lo_oe(ext_addr_lo_oe), .ext_rd(ext_rd), .ext_we(ext_we),
    .ext_wdata(ext_wdata), .ext_wdata_oe(ext_wdata_oe), .ext_rdata(ext_rdata)
  );

  function automatic logic [7:0] ram_pat(input logic [11:0] a);
    return a[7:0] ^ {4'h0, a[11:8]} ^ 8'hC3;
  endfunction

  always @(posedge clk) if (ram_en) ram_rdata <= ram_pat(ram_addr);
  assign ext_rdata = ext_addr[7:0] ^ ext_addr[15:8] ^ 8'h5A;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic access(input logic [1:0] m, input logic [7:0] pg, input logic wd,
                        input logic [7:0] p, input logic [15:0] dp, input logic w,
                        input logic [7:0] wdat, input bit gap);
    logic [15:0] eff, exp_bus;
    logic        off, hi;
    string       tag;
    int          done_n;
    eff     = wd ? dp : (m == 2'b11 ? {8'h00, p} : {pg, p});
    off     = (m == 2'b11) || (m == 2'b10 && eff >= 16'h1000);
    hi      = off && (wd || m != 2'b11);
    exp_bus = hi ? eff : {8'h00, eff[7:0]};
    if (m < 2'b10)        tag = "R6";
    else if (wd)          tag = "R3";
    else if (m == 2'b11)  tag = "R5";
    else if (off)         tag = "R2";
    else                  tag = "R1";
    done_n = off ? W + 1 : 1;

    @(posedge clk); #0.5;
    cfg_mode = m; cfg_page = pg; cpu_wide = wd; cpu_ptr = p; cpu_dptr = dp;
    cpu_we = w; cpu_wdata = wdat; cpu_req = 1'b1;
    #1;
    chk(m == 2'b11 ? "R4 ram_en" : "R7 ram_en", ram_en, !off);
    chk("R10 idle enables", {ext_addr_hi_oe, ext_addr_lo_oe, ext_wdata_oe, ext_rd, ext_we}, 0);
    if (!off) begin
      chk({tag, " ram_addr"}, ram_addr, eff[11:0]);
      chk("R7 ram_we", ram_we, w);
      if (w) chk("R7 ram_wdata", ram_wdata, wdat);
    end
    for (int n = 1; n <= done_n; n++) begin
      @(posedge clk); #1.5;
      chk("R4 ram_en busy", ram_en, 0);
      if (off) begin
        chk({tag, " ext_addr"}, ext_addr, exp_bus);
        chk({tag, " hi_oe"}, ext_addr_hi_oe, hi);
        chk("R9 lo_oe", ext_addr_lo_oe, 1);
        chk("R9 strobes", {ext_we, ext_rd, ext_wdata_oe}, {w, !w, w});
        if (w) chk("R9 ext_wdata", ext_wdata, wdat);
      end
      if (n < done_n) chk(off ? "R8 ready low" : "R7 ready low", cpu_ready, 0);
      else begin
        chk(off ? "R8 ready" : "R7 ready", cpu_ready, 1);
        if (!w) chk(off ? "R8 rdata" : "R7 rdata", cpu_rdata,
                    off ? (exp_bus[7:0] ^ exp_bus[15:8] ^ 8'h5A) : ram_pat(eff[11:0]));
      end
    end
    if (gap) begin
      @(posedge clk); #0.5;
      cpu_req = 1'b0;
      #1;
      chk("R11 ready single", cpu_ready, 0);
      chk("R10 released", {ext_addr_hi_oe, ext_addr_lo_oe, ext_wdata_oe, ext_rd, ext_we}, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL R8 watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [7:0]  pages [4] = '{8'h00, 8'h0F, 8'h10, 8'hFF};
    logic [7:0]  ptrs  [3] = '{8'h00, 8'h7F, 8'hFF};
    logic [15:0] dps   [5] = '{16'h0000, 16'h0FFF, 16'h1000, 16'hFFFF, 16'hABCD};
    int k = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset enables", {ext_addr_hi_oe, ext_addr_lo_oe, ext_wdata_oe, ext_rd, ext_we}, 0);
    chk("R11 reset ready", cpu_ready, 0);
    chk("R7 reset ram_en", ram_en, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++) begin
        for (int d = 0; d < 5; d++) begin
          access(2'(m), 8'hA5, 1'b1, 8'h3C, dps[d], w[0], 8'(d * 17 + 3), k[0]);
          k++;
        end
        for (int g = 0; g < 4; g++)
          for (int q = 0; q < 3; q++) begin
            access(2'(m), pages[g], 1'b0, ptrs[q], 16'hF00D, w[0], 8'(g * 31 + q), k[1]);
            k++;
          end
      end
    @(posedge clk); #0.5;
    cpu_req = 1'b0;
    #1;
    chk("R10 final idle", {ext_addr_hi_oe, ext_addr_lo_oe, ext_wdata_oe, ext_rd, ext_we}, 0);
    finish_run();
  end
endmodule